// File: doc/BRIEF.md
# Processor Startup Message Sequencer

This block is the per-core sequencer that decides what one logical processor does after reset, after an INIT pulse and after startup messages. After reset it runs a short self-setup, waits for the result of the boot election, and then either runs boot code (election won) or waits for a startup message (election lost). An accepted startup message moves a waiting core into its configuration routine. The vector carried by that message is latched and shown on an output while the routine runs. A completion strobe from the core then halts it.

The election result is stored in a sticky boot flag. Only reset clears it. An INIT that arrives after the election does not repeat the power-up flow. It sends the core straight to boot code if the flag is set, or to wait-for-startup if it is clear. The block also drives an interrupt-inhibit output. It is high from reset, and on a non-boot core it stays high until that core has seen the second startup message of an INIT, startup, startup sequence.

Top module: `startup_seq`

## Requirements
- R1: While rst_n is low at a clock edge, the following edge leaves run_mode = 0 (self-setup), boot_flag = 0, irq_inhibit = 1 and cfg_vector = 0.
- R2: After reset is released, run_mode stays 0 for SETUP_CYCLES cycles and then becomes 1 (awaiting election). An elect_valid during self-setup is ignored.
- R3: In mode 1, elect_valid with elect_won = 1 gives run_mode = 2 (boot code), boot_flag = 1 and irq_inhibit = 0. With elect_won = 0 it gives run_mode = 3 (wait-for-startup), boot_flag = 0 and irq_inhibit = 1.
- R4: INIT is ignored until the election has completed: self-setup and the election wait carry on unchanged.
- R5: Once the election has completed, INIT in any mode gives run_mode = 2 if boot_flag is 1, and run_mode = 3 if it is 0.
- R6: boot_flag changes only at the election or at reset. INIT never alters it.
- R7: A startup message in mode 3 gives run_mode = 4 (configuration). It latches sipi_vector, and cfg_vector shows that value while in mode 4 and 0 in every other mode.
- R8: A startup message in any mode other than 3 leaves run_mode and the latched vector unchanged.
- R9: cfg_done in mode 4 gives run_mode = 5 (halted). In any other mode it has no effect.
- R10: On a core whose boot_flag is 0, the election and every later INIT set irq_inhibit to 1. irq_inhibit drops the cycle after the second startup message received since then, and that message counts even if it was ignored. On a core whose boot_flag is 1, INIT leaves irq_inhibit at 0.
- R11: When INIT and a startup message arrive in the same cycle after the election, INIT wins. The startup message is neither accepted nor counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up or reset) |
| init_pulse | input | 1 | One-cycle INIT request |
| sipi_pulse | input | 1 | One-cycle startup message |
| sipi_vector | input | VEC_W | Vector carried by the startup message |
| elect_valid | input | 1 | Boot election result is available this cycle |
| elect_won | input | 1 | This core won the election (valid with elect_valid) |
| cfg_done | input | 1 | Configuration routine has finished |
| run_mode | output | 3 | 0 setup, 1 election wait, 2 boot code, 3 wait-for-startup, 4 configuration, 5 halted |
| boot_flag | output | 1 | Sticky boot-processor flag |
| irq_inhibit | output | 1 | Platform must hold interrupt delivery off while high |
| cfg_vector | output | VEC_W | Latched startup vector during configuration, else 0 |

## Verification
The assertions take all strobes to be single-cycle pulses sampled at the rising edge. They expect elect_valid to arrive only after self-setup, at most once per reset, although the block ignores a stray one. The stimulus drives every input at the falling edge and holds it for one full cycle. It issues one election per reset and changes nothing during reset except to check that reset clears the sticky state. A behavioural reference model is compared on every cycle, including the deliberately ignored INITs, startup messages and completion strobes.

// File: rtl/startup_pkg.sv
// Shared run-mode encoding for the startup sequencer.
// Assumes the numeric codes are visible to software and platform logic,
// so they are fixed here and nowhere else.
package startup_pkg;
    typedef enum logic [2:0] {
        MODE_SETUP  = 3'd0,
        MODE_ELECT  = 3'd1,
        MODE_BOOT   = 3'd2,
        MODE_WAIT   = 3'd3,
        MODE_CONFIG = 3'd4,
        MODE_HALT   = 3'd5
    } run_mode_t;
endpackage

// File: rtl/setup_timer.sv
// Counts the self-setup window after reset.
// Assumes LIMIT >= 1 and that run is held high only during self-setup.
module setup_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // advance the count while self-setup is running, hold at the end
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (run && cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q == LAST);

    // R2
    timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/role_store.sv
// Holds the sticky result of the boot election.
// Assumes elect_take is asserted at most once per reset; only reset clears it.
module role_store (
    input  logic clk,
    input  logic rst_n,
    input  logic elect_take,
    input  logic elect_won,
    output logic elected,
    output logic boot_flag
);
    // record that an election happened and whether this core won it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elected   <= 1'b0;
            boot_flag <= 1'b0;
        end else if (elect_take) begin
            elected   <= 1'b1;
            boot_flag <= elect_won;
        end
    end

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !elect_take |=> $stable(boot_flag));
endmodule

// File: rtl/inhibit_tracker.sv
// Drives the interrupt-inhibit output and counts startup messages since the
// last arming event. Assumes set_evt and clr_evt are mutually exclusive.
module inhibit_tracker #(
    parameter int MSG_COUNT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    input  logic msg_evt,
    output logic irq_inhibit
);
    localparam int CW = $clog2(MSG_COUNT + 1);
    localparam logic [CW-1:0] LAST = CW'(MSG_COUNT - 1);

    logic [CW-1:0] seen_q;

    // arm, release or count toward release of the inhibit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_inhibit <= 1'b1;
            seen_q      <= '0;
        end else if (set_evt) begin
            irq_inhibit <= 1'b1;
            seen_q      <= '0;
        end else if (clr_evt) begin
            irq_inhibit <= 1'b0;
            seen_q      <= '0;
        end else if (msg_evt && irq_inhibit) begin
            if (seen_q == LAST) begin
                irq_inhibit <= 1'b0;
                seen_q      <= '0;
            end else begin
                seen_q <= seen_q + 1'b1;
            end
        end
    end

    // R10
    inhibit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_inhibit && !msg_evt && !clr_evt) |=> irq_inhibit);

    // R10
    inhibit_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_inhibit && !set_evt) |=> !irq_inhibit);
endmodule

// File: rtl/vector_latch.sv
// Captures the startup vector of an accepted message and presents it only
// while the core is configuring. Assumes load is a one-cycle strobe.
module vector_latch #(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [VEC_W-1:0] vec_in,
    input  logic             show,
    output logic [VEC_W-1:0] vec_out
);
    logic [VEC_W-1:0] vec_q;

    // capture the vector on an accepted startup message
    always_ff @(posedge clk) begin
        if (!rst_n)
            vec_q <= '0;
        else if (load)
            vec_q <= vec_in;
    end

    // present the vector only during configuration
    always_comb vec_out = show ? vec_q : '0;

    // R8
    vec_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(vec_q));
endmodule

// File: rtl/startup_seq.sv
// Per-core startup sequencer: self-setup, election wait, boot code or
// wait-for-startup, configuration and halt, with a sticky boot flag that
// steers INIT after the election. Assumes all strobes are one-cycle pulses.
module startup_seq
    import startup_pkg::*;
#(
    parameter int SETUP_CYCLES = 4,
    parameter int VEC_W        = 8,
    parameter int MSG_COUNT    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_pulse,
    input  logic             sipi_pulse,
    input  logic [VEC_W-1:0] sipi_vector,
    input  logic             elect_valid,
    input  logic             elect_won,
    input  logic             cfg_done,
    output logic [2:0]       run_mode,
    output logic             boot_flag,
    output logic             irq_inhibit,
    output logic [VEC_W-1:0] cfg_vector
);
    run_mode_t state_q, state_d;
    logic      elected, setup_done;
    logic      init_take, elect_take, sipi_take, sipi_count;
    logic      set_evt, clr_evt;

    // classify this cycle's events; INIT outranks everything once elected
    always_comb begin
        init_take  = init_pulse && elected;
        elect_take = (state_q == MODE_ELECT) && elect_valid;
        sipi_take  = (state_q == MODE_WAIT) && sipi_pulse && !init_take;
        sipi_count = sipi_pulse && elected && !boot_flag && !init_take;
        set_evt    = (elect_take && !elect_won) || (init_take && !boot_flag);
        clr_evt    = (elect_take && elect_won) || (init_take && boot_flag);
    end

    // next-state selection for the run mode
    always_comb begin
        state_d = state_q;
        if (init_take) begin
            state_d = boot_flag ? MODE_BOOT : MODE_WAIT;
        end else begin
            unique case (state_q)
                MODE_SETUP:  if (setup_done) state_d = MODE_ELECT;
                MODE_ELECT:  if (elect_valid)
                                 state_d = elect_won ? MODE_BOOT : MODE_WAIT;
                MODE_WAIT:   if (sipi_pulse) state_d = MODE_CONFIG;
                MODE_CONFIG: if (cfg_done) state_d = MODE_HALT;
                default:     state_d = state_q;
            endcase
        end
    end

    // run-mode register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= MODE_SETUP;
        else
            state_q <= state_d;
    end

    assign run_mode = state_q;

    setup_timer #(.LIMIT(SETUP_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == MODE_SETUP),
        .expired (setup_done)
    );

    role_store u_role (
        .clk        (clk),
        .rst_n      (rst_n),
        .elect_take (elect_take),
        .elect_won  (elect_won),
        .elected    (elected),
        .boot_flag  (boot_flag)
    );

    inhibit_tracker #(.MSG_COUNT(MSG_COUNT)) u_inhibit (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_evt     (set_evt),
        .clr_evt     (clr_evt),
        .msg_evt     (sipi_count),
        .irq_inhibit (irq_inhibit)
    );

    vector_latch #(.VEC_W(VEC_W)) u_vec (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sipi_take),
        .vec_in  (sipi_vector),
        .show    (state_q == MODE_CONFIG),
        .vec_out (cfg_vector)
    );

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (run_mode == 3'd0 && !boot_flag && irq_inhibit && cfg_vector == '0));

    // R4
    early_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_SETUP && init_pulse) |=> (run_mode == 3'd0 || run_mode == 3'd1));

    // R5
    init_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (init_pulse && elected && boot_flag) |=> run_mode == 3'd2);

    // R7
    sipi_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_mode == 3'd3 && sipi_pulse && !init_pulse)
            |=> (run_mode == 3'd4 && cfg_vector == $past(sipi_vector)));

    // R8
    halt_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_mode == 3'd5 && !init_pulse) |=> run_mode == 3'd5);

    // R9
    cfg_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_mode == 3'd4 && cfg_done && !init_pulse) |=> run_mode == 3'd5);
endmodule

// File: tb/tb_startup_seq.sv
module tb_startup_seq;
    localparam int SETUP_CYCLES = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       init_pulse = 1'b0, sipi_pulse = 1'b0;
    logic [7:0] sipi_vector = 8'h00;
    logic       elect_valid = 1'b0, elect_won = 1'b0, cfg_done = 1'b0;
    logic [2:0] run_mode;
    logic       boot_flag, irq_inhibit;
    logic [7:0] cfg_vector;

    int checks = 0, errors = 0;
    bit comparing = 0;
    string phase = "R1";

    // behavioural reference state
    int m_mode = 0, m_sc = 0, m_flag = 0, m_done = 0, m_inh = 1, m_cnt = 0, m_vec = 0;

    always #2 clk = ~clk;

    startup_seq #(.SETUP_CYCLES(SETUP_CYCLES)) dut (
        .clk(clk), .rst_n(rst_n), .init_pulse(init_pulse), .sipi_pulse(sipi_pulse),
        .sipi_vector(sipi_vector), .elect_valid(elect_valid), .elect_won(elect_won),
        .cfg_done(cfg_done), .run_mode(run_mode), .boot_flag(boot_flag),
        .irq_inhibit(irq_inhibit), .cfg_vector(cfg_vector)
    );

    // reference model, advanced at every rising edge
    always @(posedge clk) begin
        int pre_done, pre_flag;
        pre_done = m_done;
        pre_flag = m_flag;
        if (!rst_n) begin
            m_mode = 0; m_sc = 0; m_flag = 0; m_done = 0; m_inh = 1; m_cnt = 0; m_vec = 0;
        end else if (init_pulse && pre_done) begin
            m_mode = pre_flag ? 2 : 3;
            m_inh  = pre_flag ? 0 : 1;
            m_cnt  = 0;
        end else begin
            case (m_mode)
                0: if (m_sc == SETUP_CYCLES - 1) m_mode = 1; else m_sc++;
                1: if (elect_valid) begin
                       m_done = 1; m_flag = elect_won;
                       m_mode = elect_won ? 2 : 3;
                       m_inh = elect_won ? 0 : 1; m_cnt = 0;
                   end
                3: if (sipi_pulse) begin m_mode = 4; m_vec = sipi_vector; end
                4: if (cfg_done) m_mode = 5;
                default: ;
            endcase
            if (sipi_pulse && pre_done && !pre_flag && m_inh == 1) begin
                m_cnt++;
                if (m_cnt == 2) begin m_inh = 0; m_cnt = 0; end
            end
        end
    end

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // compare against the model on every falling edge
    always @(negedge clk) begin
        if (comparing) begin
            check(phase, "run_mode", int'(run_mode), m_mode);
            check(phase, "boot_flag", int'(boot_flag), m_flag);
            check(phase, "irq_inhibit", int'(irq_inhibit), m_inh);
            check(phase, "cfg_vector", int'(cfg_vector), (m_mode == 4) ? m_vec : 0);
        end
    end

    // drive one cycle of inputs at the falling edge
    task automatic cyc(bit i, bit s, logic [7:0] v, bit e, bit w, bit c);
        @(negedge clk);
        init_pulse = i; sipi_pulse = s; sipi_vector = v;
        elect_valid = e; elect_won = w; cfg_done = c;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) cyc(0, 0, 8'h00, 0, 0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        comparing = 1;
        phase = "R1";
        idle(1);
        // directed reset check
        @(negedge clk);
        check("R1", "reset mode", int'(run_mode), 0);
        check("R1", "reset inhibit", int'(irq_inhibit), 1);
        @(negedge clk);
        rst_n = 1'b1;

        // self-setup with a stray election result and an early INIT
        phase = "R2";
        cyc(0, 0, 8'h00, 1, 1, 0);
        phase = "R4";
        cyc(1, 0, 8'h00, 0, 0, 0);
        cyc(0, 1, 8'h33, 0, 0, 0);
        idle(2);
        phase = "R4";
        cyc(1, 0, 8'h00, 0, 0, 0);
        idle(1);

        // lose the election, then INIT-SIPI-SIPI
        phase = "R3";
        cyc(0, 0, 8'h00, 1, 0, 0);
        idle(1);
        phase = "R9";
        cyc(0, 0, 8'h00, 0, 0, 1);
        phase = "R7";
        cyc(0, 1, 8'h5A, 0, 0, 0);
        idle(1);
        phase = "R10";
        cyc(0, 1, 8'hC3, 0, 0, 0);
        idle(2);
        @(negedge clk);
        check("R7", "vector shown", int'(cfg_vector), 8'h5A);
        check("R10", "inhibit released", int'(irq_inhibit), 0);
        phase = "R9";
        cyc(0, 0, 8'h00, 0, 0, 1);
        idle(1);
        phase = "R8";
        cyc(0, 1, 8'h11, 0, 0, 0);
        idle(1);

        // INIT after election on a non-boot core
        phase = "R5";
        cyc(1, 0, 8'h00, 0, 0, 0);
        idle(1);
        phase = "R6";
        cyc(0, 0, 8'h00, 1, 1, 0);
        idle(1);
        phase = "R11";
        cyc(1, 1, 8'h77, 0, 0, 0);
        idle(1);
        phase = "R10";
        cyc(0, 1, 8'h90, 0, 0, 0);
        cyc(0, 1, 8'h91, 0, 0, 0);
        idle(1);
        phase = "R8";
        cyc(0, 1, 8'h92, 0, 0, 0);
        idle(1);
        phase = "R9";
        cyc(0, 0, 8'h00, 0, 0, 1);
        idle(2);

        // reset clears the sticky state; this time win the election
        phase = "R1";
        do_reset();
        idle(SETUP_CYCLES + 1);
        phase = "R3";
        cyc(0, 0, 8'h00, 1, 1, 0);
        idle(1);
        phase = "R8";
        cyc(0, 1, 8'h44, 0, 0, 0);
        idle(1);
        phase = "R9";
        cyc(0, 0, 8'h00, 0, 0, 1);
        idle(1);
        phase = "R5";
        cyc(1, 0, 8'h00, 0, 0, 0);
        idle(1);
        @(negedge clk);
        check("R5", "boot after INIT", int'(run_mode), 2);
        check("R6", "flag kept", int'(boot_flag), 1);
        phase = "R10";
        cyc(1, 1, 8'h00, 0, 0, 0);
        idle(2);

        // reset mid-run drops the flag again
        phase = "R1";
        do_reset();
        idle(2);
        @(negedge clk);
        check("R1", "flag cleared", int'(boot_flag), 0);
        idle(2);

        comparing = 0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule